// File: doc/BRIEF.md
# Lazy Coprocessor-Context Trap Controller

This block keeps the three control flags that decide whether the floating-point and SIMD unit may be used by the running task. The three flags are task-switched, emulate and monitor-coprocessor. A hardware task switch sets the task-switched flag. Until software clears that flag, the first floating-point or SIMD instruction of the new task raises a device-not-available fault. The fault handler can then save the old task's unit state and load the new one, so that state is only moved when a task actually uses the unit.

Each cycle the decoder may present one classified instruction. The block judges it against the flags as they were held at the start of that cycle. One cycle later it reports either a fault pulse or an execute permit. The instruction input is a valid-only stream: the block never applies back-pressure, so there is no ready signal and every presented instruction is judged. The flags are visible at all times through a control-word output, at the same bit positions the write port uses.

Top module: `fpctx_trap`

## Requirements
- R1: After reset, all three flags are clear, `ctl_word` reads zero, and both `fault` and `exec_ok` are low.
- R2: A `task_switch` pulse sets the task-switched flag (bit 3 of `ctl_word`) from the next cycle on.
- R3: A `clear_ts` pulse clears the task-switched flag and leaves the emulate flag (bit 2) and the monitor flag (bit 1) unchanged.
- R4: A control write loads task-switched, emulate and monitor from `cw_wr_data` bits 3, 2 and 1. Every other bit of `ctl_word` always reads zero.
- R5: An instruction of class x87 (code 1), MMX (2) or SSE (3) presented while task-switched=1 and emulate=0 gives `fault`=1 and `exec_ok`=0 in the following cycle.
- R6: An instruction of the exempt class (code 5: pause, prefetch, fences, non-temporal store, cache-line flush) never faults.
- R7: A WAIT instruction (code 4) faults only when task-switched=1, monitor=1 and emulate=0. With monitor=0 it never faults.
- R8: While emulate=1, no instruction class faults, whatever the task-switched flag holds.
- R9: Instructions of class other (code 0) and the unused codes 6 and 7 never fault.
- R10: Each valid instruction yields exactly one verdict in the next cycle: either `fault` or `exec_ok` is high, never both. A cycle with no valid instruction yields neither in the next cycle.
- R11: Within one cycle, `task_switch` wins over `clear_ts` and over the written task-switched bit, and `clear_ts` wins over the written task-switched bit.
- R12: An instruction is judged against the flags held before any update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_switch | input | 1 | Hardware task-switch event |
| clear_ts | input | 1 | Command that clears only the task-switched flag |
| cw_wr_en | input | 1 | Control-word write strobe |
| cw_wr_data | input | CW_W | Control-word write value (bits 3, 2, 1 used) |
| ins_valid | input | 1 | A classified instruction is presented (always accepted) |
| ins_class | input | 3 | Instruction class code |
| ctl_word | output | CW_W | Current flags at bits 3 (task-switched), 2 (emulate), 1 (monitor) |
| fault | output | 1 | Device-not-available fault pulse for the previous cycle's instruction |
| exec_ok | output | 1 | Execute permit for the previous cycle's instruction |

## Verification
Assertions check every cycle that a task switch sets the flag and wins any same-cycle conflict. They also check that a clear leaves emulate and monitor untouched, that a write lands at the stated bit positions, and that exempt, other-class and emulated instructions never fault. Further assertions check that fault and permit are never high together and that an empty cycle produces no verdict. Only the bench scenarios show the positive cases: a faulting instruction really raising the pulse for each floating-point and SIMD class, the WAIT dependence on the monitor flag, and an instruction judged against the old flags when a switch or a clear lands in the same cycle.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    IC_OTHER  = 3'd0,
    IC_X87    = 3'd1,
    IC_MMX    = 3'd2,
    IC_SSE    = 3'd3,
    IC_WAIT   = 3'd4,
    IC_EXEMPT = 3'd5
  } ins_class_e;

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
  } flags_t;

endpackage

// File: rtl/fpctx_flags.sv
module fpctx_flags
  import fpctx_pkg::*;
#(
  parameter int CW_W   = 32,
  parameter int TS_BIT = 3,
  parameter int EM_BIT = 2,
  parameter int MP_BIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            task_switch,
  input  logic            clear_ts,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  output flags_t          flags_q
);

  flags_t flags_d;

  // Priority, lowest first: write, clear, task switch.
  always_comb begin
    flags_d = flags_q;
    if (wr_en) begin
      flags_d.ts = wr_data[TS_BIT];
      flags_d.em = wr_data[EM_BIT];
      flags_d.mp = wr_data[MP_BIT];
    end
    if (clear_ts)    flags_d.ts = 1'b0;
    if (task_switch) flags_d.ts = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R2 / R11: a switch always leaves the flag set
  a_r2_switch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> flags_q.ts);

  // R3: clear touches only the task-switched flag
  a_r3_clear_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ts && !task_switch && !wr_en) |=> (!flags_q.ts && $stable(flags_q.em) && $stable(flags_q.mp)));

  // R11: clear beats the written task-switched bit
  a_r11_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ts && wr_en && !task_switch) |=> !flags_q.ts);

  // R4: write lands at the fixed bit positions
  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear_ts && !task_switch) |=>
      (flags_q.ts == $past(wr_data[TS_BIT]) && flags_q.em == $past(wr_data[EM_BIT])
       && flags_q.mp == $past(wr_data[MP_BIT])));

endmodule

// File: rtl/fpctx_decide.sv
module fpctx_decide
  import fpctx_pkg::*;
(
  input  flags_t           flags,
  input  logic             ins_valid,
  input  logic [CLS_W-1:0] ins_class,
  output logic             fault_d,
  output logic             permit_d
);

  logic trap;

  always_comb begin
    trap = 1'b0;
    case (ins_class)
      IC_X87, IC_MMX, IC_SSE: trap = flags.ts && !flags.em;
      IC_WAIT:                trap = flags.ts && flags.mp && !flags.em;
      default:                trap = 1'b0;
    endcase
    fault_d  = ins_valid && trap;
    permit_d = ins_valid && !trap;
  end

endmodule

// File: rtl/fpctx_trap.sv
module fpctx_trap
  import fpctx_pkg::*;
#(
  parameter int CW_W   = 32,
  parameter int TS_BIT = 3,
  parameter int EM_BIT = 2,
  parameter int MP_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             task_switch,
  input  logic             clear_ts,
  input  logic             cw_wr_en,
  input  logic [CW_W-1:0]  cw_wr_data,
  input  logic             ins_valid,
  input  logic [CLS_W-1:0] ins_class,
  output logic [CW_W-1:0]  ctl_word,
  output logic             fault,
  output logic             exec_ok
);

  flags_t flags_q;
  logic   fault_d;
  logic   permit_d;

  fpctx_flags #(
    .CW_W(CW_W), .TS_BIT(TS_BIT), .EM_BIT(EM_BIT), .MP_BIT(MP_BIT)
  ) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .task_switch (task_switch),
    .clear_ts    (clear_ts),
    .wr_en       (cw_wr_en),
    .wr_data     (cw_wr_data),
    .flags_q     (flags_q)
  );

  fpctx_decide u_decide (
    .flags     (flags_q),
    .ins_valid (ins_valid),
    .ins_class (ins_class),
    .fault_d   (fault_d),
    .permit_d  (permit_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault   <= 1'b0;
      exec_ok <= 1'b0;
    end else begin
      fault   <= fault_d;
      exec_ok <= permit_d;
    end
  end

  for (genvar i = 0; i < CW_W; i++) begin : g_cw
    if (i == TS_BIT) begin : g_ts
      assign ctl_word[i] = flags_q.ts;
    end else if (i == EM_BIT) begin : g_em
      assign ctl_word[i] = flags_q.em;
    end else if (i == MP_BIT) begin : g_mp
      assign ctl_word[i] = flags_q.mp;
    end else begin : g_zero
      assign ctl_word[i] = 1'b0;
    end
  end

  // R10: one verdict, never both
  a_r10_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && exec_ok));

  a_r10_idle_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> (!fault && !exec_ok));

  // R6: exempt class never faults
  a_r6_exempt_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class == IC_EXEMPT) |=> (!fault && exec_ok));

  // R9: non-unit classes never fault
  a_r9_other_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (ins_class == IC_OTHER || ins_class > IC_EXEMPT)) |=> !fault);

  // R8: emulation masks the task-switched flag
  a_r8_em_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ctl_word[EM_BIT]) |=> !fault);

  // R7: WAIT without monitor never faults
  a_r7_wait_no_mp: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class == IC_WAIT && !ctl_word[MP_BIT]) |=> !fault);

endmodule

// File: tb/fpctx_trap_bench.sv
module fpctx_trap_bench;
  localparam int CW_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            task_switch = 1'b0;
  logic            clear_ts = 1'b0;
  logic            cw_wr_en = 1'b0;
  logic [CW_W-1:0] cw_wr_data = '0;
  logic            ins_valid = 1'b0;
  logic [2:0]      ins_class = 3'd0;
  logic [CW_W-1:0] ctl_word;
  logic            fault;
  logic            exec_ok;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpctx_trap #(.CW_W(CW_W)) u_fpctx_trap (
    .clk(clk), .rst_n(rst_n), .task_switch(task_switch), .clear_ts(clear_ts),
    .cw_wr_en(cw_wr_en), .cw_wr_data(cw_wr_data), .ins_valid(ins_valid),
    .ins_class(ins_class), .ctl_word(ctl_word), .fault(fault), .exec_ok(exec_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, then sample 1 ns after the edge.
  task automatic cyc(input bit sw, input bit clr, input bit wr, input logic [31:0] d,
                     input bit v, input logic [2:0] cls);
    task_switch = sw; clear_ts = clr; cw_wr_en = wr; cw_wr_data = d;
    ins_valid = v; ins_class = cls;
    @(posedge clk); #1;
    task_switch = 0; clear_ts = 0; cw_wr_en = 0; cw_wr_data = '0;
    ins_valid = 0; ins_class = 3'd0;
  endtask

  task automatic write_cw(input logic [31:0] d);
    cyc(0, 0, 1, d, 0, 0);
  endtask

  task automatic issue(input string req, input logic [2:0] cls, input bit exp_fault);
    cyc(0, 0, 0, 0, 1, cls);
    chk(req, {30'd0, fault, exec_ok}, {30'd0, exp_fault, !exp_fault});
  endtask

  task automatic t_reset;
    chk("R1 ctl_word", ctl_word, 32'h0);
    chk("R1 verdict", {30'd0, fault, exec_ok}, 32'h0);
  endtask

  task automatic t_write;
    write_cw(32'hFFFF_FFFF);
    chk("R4 all ones", ctl_word, 32'h0000_000E);
    write_cw(32'h0000_0004);
    chk("R4 em only", ctl_word, 32'h0000_0004);
    write_cw(32'h0);
    chk("R4 zero", ctl_word, 32'h0);
  endtask

  task automatic t_switch;
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 switch sets", ctl_word, 32'h8);
    chk("R10 idle no verdict", {30'd0, fault, exec_ok}, 32'h0);
  endtask

  task automatic t_fp;
    write_cw(32'h8);
    issue("R5 x87", 3'd1, 1);
    issue("R5 mmx", 3'd2, 1);
    issue("R5 sse", 3'd3, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10 pulse ends", {30'd0, fault, exec_ok}, 32'h0);
  endtask

  task automatic t_exempt_other;
    write_cw(32'hA);
    issue("R6 exempt", 3'd5, 0);
    issue("R9 other", 3'd0, 0);
    issue("R9 code6", 3'd6, 0);
    issue("R9 code7", 3'd7, 0);
  endtask

  task automatic t_wait;
    write_cw(32'h8);
    issue("R7 wait mp0", 3'd4, 0);
    write_cw(32'hA);
    issue("R7 wait mp1", 3'd4, 1);
    write_cw(32'h2);
    issue("R7 wait ts0", 3'd4, 0);
  endtask

  task automatic t_em;
    write_cw(32'hE);
    for (int c = 0; c < 8; c++) issue("R8 em masks", 3'(c), 0);
  endtask

  task automatic t_clear;
    write_cw(32'hE);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R3 clear keeps em mp", ctl_word, 32'h6);
    write_cw(32'hA);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R3 clear keeps mp", ctl_word, 32'h2);
  endtask

  task automatic t_prio;
    write_cw(32'h0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R11 switch beats clear", ctl_word, 32'h8);
    cyc(1, 0, 1, 32'h4, 0, 0);
    chk("R11 switch beats write", ctl_word, 32'hC);
    cyc(0, 1, 1, 32'hA, 0, 0);
    chk("R11 clear beats write", ctl_word, 32'h2);
  endtask

  task automatic t_same_cycle;
    write_cw(32'h0);
    cyc(1, 0, 0, 0, 1, 3'd1);
    chk("R12 old flags on switch", {30'd0, fault, exec_ok}, 32'h1);
    chk("R12 flag now set", ctl_word, 32'h8);
    cyc(0, 1, 0, 0, 1, 3'd2);
    chk("R12 old flags on clear", {30'd0, fault, exec_ok}, 32'h2);
    chk("R12 flag now clear", ctl_word, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_write();
    t_switch();
    t_fp();
    t_exempt_other();
    t_wait();
    t_em();
    t_clear();
    t_prio();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule